// File: doc/BRIEF.md
# ChaCha20 Keystream Block Generator

This block turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into one 512-bit ChaCha20 keystream block. It assembles the sixteen-word working state from four fixed constants, the key, the counter and the nonce. It then applies twenty rounds of add-rotate-xor mixing and adds the original state back onto the result. Combining the keystream with data, framing messages and advancing the counter from one block to the next are left to the surrounding logic.

A single pulse on `start` while the block is idle captures the inputs and begins a run. The datapath is iterative. Each clock cycle performs one half of a double round: either the four column quarter-rounds or the four diagonal quarter-rounds. A block therefore takes `ROUNDS` cycles. When the run completes, `done` is high for one cycle and the keystream appears on `ks`. That value stays on `ks` until the next run finishes.

Top module: `chacha_block`

## Requirements
- R1: The initial state is laid out as follows. Words 0..3 are 0x61707865, 0x3320646E, 0x79622D32 and 0x6B206574. Word 4+i is `key[32*i+31:32*i]` for i = 0..7, so key byte j sits at `key[8*j+7:8*j]` and each word is read little-endian. Word 12 is `blk_ctr`. Word 13+k is `nonce[32*k+31:32*k]` for k = 0..2.
- R2: One quarter-round on (a,b,c,d) performs these steps in order: a+=b, d^=a, d rotated left by 16; c+=d, b^=c, b rotated left by 12; a+=b, d^=a, d rotated left by 8; c+=d, b^=c, b rotated left by 7. Every sum wraps modulo 2^32 and every rotation is a 32-bit circular rotation.
- R3: Each double round first runs quarter-rounds on the columns (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). It then runs them on the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). With `ROUNDS`=20, ten double rounds are applied.
- R4: Output word i, placed at `ks[32*i+31:32*i]`, is the final round state word i plus initial state word i, modulo 2^32.
- R5: `start` is accepted when it is sampled high while `busy` is low. If it is accepted at clock edge k, `busy` is high in the `ROUNDS` cycles that follow edges k..k+ROUNDS-1, and `done` and the new `ks` appear after edge k+ROUNDS.
- R6: `done` stays high for exactly one cycle per accepted start, and `busy` and `done` are never high together.
- R7: `start` is ignored while `busy` is high. The key, nonce and counter are sampled only at an accepted start, so changing them during a run does not alter its result.
- R8: `ks` changes only in the cycle in which `done` rises. Otherwise it holds its value.
- R9: A synchronous active-high `rst` clears `busy`, `done`, the round counter and `ks` to zero, and it also aborts a run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to compute one block |
| key | input | 256 | Key, word i at bits 32i+31:32i |
| nonce | input | 96 | Nonce, word k at bits 32k+31:32k |
| blk_ctr | input | 32 | Block counter placed in state word 12 |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when `ks` is new |
| ks | output | 512 | Keystream block, word i at bits 32i+31:32i |

## Verification
Every keystream is due exactly `ROUNDS` clock edges after the edge that accepts `start`. The driver records that due cycle beside the expected block in the scoreboard queue. The monitor samples on the falling edge, and on each `done` it compares both the data and the arrival cycle. A `done` that arrives with an empty queue is reported, and so is any movement of `ks` in a cycle without `done`. Because of this, a stray restart or a wrong cycle count shows up within the same run.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

    typedef logic [31:0] word_t;
    typedef word_t [15:0] state_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int NUM_WORDS = 16;
    localparam int KEY_WORDS = 8;
    localparam int NONCE_WORDS = 3;

    function automatic word_t sigma(input int idx);
        case (idx)
            0:       return 32'h61707865;
            1:       return 32'h3320646E;
            2:       return 32'h79622D32;
            default: return 32'h6B206574;
        endcase
    endfunction

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic quad_t quarter(input quad_t q);
        quad_t r;
        r = q;
        r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 16);
        r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 12);
        r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 8);
        r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 7);
        return r;
    endfunction

    function automatic state_t build_state(input logic [255:0] key,
                                           input logic [95:0]  nonce,
                                           input word_t        ctr);
        state_t s;
        for (int i = 0; i < 4; i++)           s[i]      = sigma(i);
        for (int i = 0; i < KEY_WORDS; i++)   s[4 + i]  = key[32*i +: 32];
        s[12] = ctr;
        for (int k = 0; k < NONCE_WORDS; k++) s[13 + k] = nonce[32*k +: 32];
        return s;
    endfunction

    function automatic state_t feed_fwd(input state_t fin, input state_t orig);
        state_t s;
        for (int i = 0; i < NUM_WORDS; i++) s[i] = fin[i] + orig[i];
        return s;
    endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
    import chacha_pkg::*;
(
    input  quad_t q_i,
    output quad_t q_o
);
    assign q_o = quarter(q_i);
endmodule

// File: rtl/chacha_half_round.sv
module chacha_half_round
    import chacha_pkg::*;
(
    input  state_t st_i,
    input  logic   diag,
    output state_t st_o
);
    localparam int LANES = 4;

    quad_t q_in  [LANES];
    quad_t q_out [LANES];

    // Gather: lane g reads column g, or the diagonal starting at word g.
    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            q_in[g].a = st_i[g];
            q_in[g].b = diag ? st_i[4  + ((g + 1) % 4)] : st_i[4  + g];
            q_in[g].c = diag ? st_i[8  + ((g + 2) % 4)] : st_i[8  + g];
            q_in[g].d = diag ? st_i[12 + ((g + 3) % 4)] : st_i[12 + g];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        chacha_qr u_qr (
            .q_i (q_in[g]),
            .q_o (q_out[g])
        );
    end

    // Scatter: row r position j came from the lane whose diagonal hit it.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            st_o[j]      = q_out[j].a;
            st_o[4 + j]  = diag ? q_out[(j + 3) % 4].b : q_out[j].b;
            st_o[8 + j]  = diag ? q_out[(j + 2) % 4].c : q_out[j].c;
            st_o[12 + j] = diag ? q_out[(j + 1) % 4].d : q_out[j].d;
        end
    end
endmodule

// File: rtl/chacha_seq.sv
module chacha_seq
    import chacha_pkg::*;
#(
    parameter int ROUNDS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic diag,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(ROUNDS - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign busy = (phase_q == PH_RUN);
    assign load = start && !busy;
    assign step = busy;
    assign diag = cnt_q[0];
    assign last = busy && (cnt_q == LAST_CNT);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                phase_q <= PH_RUN;
                cnt_q   <= '0;
            end else if (busy) begin
                if (last) begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/chacha_block.sv
module chacha_block
    import chacha_pkg::*;
#(
    parameter int ROUNDS = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [255:0] key,
    input  logic [95:0]  nonce,
    input  logic [31:0]  blk_ctr,
    output logic         busy,
    output logic         done,
    output logic [511:0] ks
);
    state_t work_q;
    state_t init_q;
    state_t next_st;
    state_t ks_q;
    logic   load;
    logic   step;
    logic   diag;
    logic   last;

    chacha_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .diag  (diag),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    chacha_half_round u_half (
        .st_i (work_q),
        .diag (diag),
        .st_o (next_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            init_q <= '0;
            ks_q   <= '0;
        end else if (load) begin
            work_q <= build_state(key, nonce, blk_ctr);
            init_q <= build_state(key, nonce, blk_ctr);
        end else if (step) begin
            work_q <= next_st;
            if (last) ks_q <= feed_fwd(next_st, init_q);
        end
    end

    assign ks = ks_q;
endmodule

// File: rtl/chacha_block_chk.sv
module chacha_block_chk #(
    parameter int ROUNDS = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [511:0] ks
);
    localparam int BW = $clog2(ROUNDS + 1) + 1;

    logic [BW-1:0] busy_cnt;
    logic          rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    // R9
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !done));

    // R5
    a_r5_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == BW'(ROUNDS)));

    // R6
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    a_r7_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start && busy_cnt < BW'(ROUNDS - 1)) |=> busy);

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !rst_d) |-> $stable(ks));
endmodule

bind chacha_block chacha_block_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ks    (ks)
);

// File: tb/chacha_block_bench.sv
`timescale 1ns/1ps
module chacha_block_bench;
    localparam int ROUNDS = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [255:0] key = '0;
    logic [95:0]  nonce = '0;
    logic [31:0]  blk_ctr = '0;
    logic         busy;
    logic         done;
    logic [511:0] ks;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [511:0] exp_q [$];
    int           due_q [$];
    logic [511:0] last_ks = '0;
    logic         prev_done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chacha_block #(.ROUNDS(ROUNDS)) u_chacha_block (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .key     (key),
        .nonce   (nonce),
        .blk_ctr (blk_ctr),
        .busy    (busy),
        .done    (done),
        .ks      (ks)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic void mix(ref logic [31:0] x[16], input int a, input int b,
                                input int c, input int d);
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 12);
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 7);
    endfunction

    function automatic logic [511:0] model(input logic [255:0] k,
                                           input logic [95:0] n,
                                           input logic [31:0] c);
        logic [31:0]  s[16];
        logic [31:0]  x[16];
        logic [511:0] o;
        s[0] = 32'h61707865; s[1] = 32'h3320646E;
        s[2] = 32'h79622D32; s[3] = 32'h6B206574;
        for (int i = 0; i < 8; i++) s[4 + i] = k[32*i +: 32];
        s[12] = c;
        for (int i = 0; i < 3; i++) s[13 + i] = n[32*i +: 32];
        x = s;
        for (int r = 0; r < ROUNDS / 2; r++) begin
            mix(x, 0, 4, 8, 12);  mix(x, 1, 5, 9, 13);
            mix(x, 2, 6, 10, 14); mix(x, 3, 7, 11, 15);
            mix(x, 0, 5, 10, 15); mix(x, 1, 6, 11, 12);
            mix(x, 2, 7, 8, 13);  mix(x, 3, 4, 9, 14);
        end
        for (int i = 0; i < 16; i++) o[32*i +: 32] = x[i] + s[i];
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: start one block and push its expected result and due cycle.
    task automatic send(input logic [255:0] k, input logic [95:0] n,
                        input logic [31:0] c);
        @(negedge clk);
        while (busy) @(negedge clk);
        key = k; nonce = n; blk_ctr = c; start = 1'b1;
        exp_q.push_back(model(k, n, c));
        due_q.push_back(cyc + 1 + ROUNDS);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            last_ks = ks;
            prev_done = 1'b0;
        end else begin
            if (done) begin
                check(!busy, "R6", "busy with done", {511'd0, busy}, 512'd0);
                check(!prev_done, "R6", "done longer than one cycle",
                      {511'd0, prev_done}, 512'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", ks, 512'd0);
                end else begin
                    logic [511:0] e;
                    int d;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    check(ks === e, "R4", "keystream", ks, e);
                    check(cyc == d, "R5", "done cycle", 512'(cyc), 512'(d));
                end
                last_ks = ks;
            end else begin
                check(ks === last_ks, "R8", "ks moved without done", ks, last_ks);
            end
            prev_done = done;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [255:0] k;
        logic [95:0]  n;
        logic [511:0] v;

        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ks === '0, "R9", "reset state",
              {ks[509:0], busy, done}, 512'd0);
        rst = 1'b0;

        // Known-answer block: key bytes 0..31, counter 1 (R1 R2 R3).
        for (int j = 0; j < 32; j++) k[8*j +: 8] = 8'(j);
        n = {32'h00000000, 32'h4a000000, 32'h09000000};
        send(k, n, 32'd1);
        wait_done();
        check(ks[31:0] == 32'he4e7f110, "R1", "known word 0",
              512'(ks[31:0]), 512'h e4e7f110);
        check(ks[511:480] == 32'h4e3c50a2, "R3", "known word 15",
              512'(ks[511:480]), 512'h4e3c50a2);
        check(ks[255:224] == 32'h4e6cd4c3, "R2", "known word 7",
              512'(ks[255:224]), 512'h4e6cd4c3);

        // All-zero inputs (R1).
        send('0, '0, '0);
        wait_done();
        check(ks[31:0] == 32'hade0b876, "R1", "zero block word 0",
              512'(ks[31:0]), 512'hade0b876);

        // All-ones with counter at max: wrap of every sum (R2 R4).
        send({256{1'b1}}, {96{1'b1}}, 32'hFFFFFFFF);
        wait_done();

        // Assorted inputs, back to back (R4 R5).
        for (int t = 0; t < 4; t++) begin
            for (int w = 0; w < 8; w++) k[32*w +: 32] = $urandom();
            for (int w = 0; w < 3; w++) n[32*w +: 32] = $urandom();
            send(k, n, $urandom());
        end
        wait_done();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);

        // R7: restart requests and input changes during a run are ignored.
        send(k, n, 32'h00000010);
        repeat (4) @(negedge clk);
        key = ~k; nonce = ~n; blk_ctr = 32'h55; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R7", "no extra blocks queued",
              512'(exp_q.size()), 512'd0);

        // R8: output held while the next block runs.
        v = ks;
        send(~k, n, 32'h7);
        repeat (10) @(negedge clk);
        check(ks === v, "R8", "ks during next run", ks, v);
        wait_done();

        // R9: reset mid-run aborts and clears.
        send(k, ~n, 32'h3);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        due_q.delete();
        repeat (2) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ks === '0, "R9", "reset mid-run",
              {ks[509:0], busy, done}, 512'd0);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check(done === 1'b0, "R9", "aborted run never completes",
              {511'd0, done}, 512'd0);

        send(k, ~n, 32'h3);
        wait_done();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5", "queue drained", 512'(exp_q.size()), 512'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule